// File: doc/BRIEF.md
# Up/Down Counter Reload PWM

This block produces a pulse-width-modulated drive signal whose frequency never changes and whose duty cycle is set by one 8-bit value that software writes into a holding register. A single up/down counter advances once per tick of a slow clock-enable strobe. That strobe is divided down from the system clock, and its default division gives about a 313 kHz rate. On each phase boundary the counter is reloaded from the holding register, its direction reverses, and a PWM flip-flop toggles. The output is low while the counter climbs and high while it descends. An up phase and a down phase together always last 255 ticks. The holding value therefore sets only the share of each period that is high.

The flip-flop feeds two gated paths, one for a pump and one for a valve. Each path has its own enable bit in a control register. If software sets both enables at once, the block forces both paths inactive. Both registers sit behind a small write port and a combinational read port.

Top module: `updown_reload_pwm`

## Requirements
- R1: After reset both outputs are low and both registers read back as 0.
- R2: The counter moves and the PWM level changes only on a tick, and ticks come once every TICK_DIV system clocks. Every phase therefore lasts a whole number of TICK_DIV-clock ticks.
- R3: For a holding value h from 1 to 254, an enabled output is high for h ticks and low for 255-h ticks. The period is a fixed 255 ticks.
- R4: With h = 0 the PWM level stays low with no pulse at all.
- R5: With h = 255 the PWM level stays high with no gap at all, once the phase in progress has finished.
- R6: A write to the holding register does not change the length of the phase in progress. The new value first applies at the next reload.
- R7: The pump output shows the PWM level when control bit 0 is 1 and bit 1 is 0. The valve output shows it when bit 1 is 1 and bit 0 is 0. Otherwise each output is low.
- R8: With control bits 0 and 1 both set, both outputs stay low whatever the PWM level.
- R9: Address 0 holds the holding register and address 1 holds the control register. Both read back the full 8 bits last written. Any other address reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Read data, combinational from rd_addr_i |
| pump_pwm_o | output | 1 | Gated PWM to the pump path |
| valve_pwm_o | output | 1 | Gated PWM to the valve path |

## Verification
A software write to the holding register can land in the same clock as a reload tick, or partway through a phase that is about to end. The bench writes a new value while the output is high and then measures three things: the high time still in progress, the following low time and the next high time. From these it judges whether the old value finished its phase and the new one began exactly at the reload. A clocked property also checks that every reload loads the holding value present in that very cycle. The enable pair changing while the flip-flop toggles is the second overlap. The bench judges it by holding the level steady at full scale and stepping through all four enable codes.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    localparam int unsigned REG_HOLD  = 0;
    localparam int unsigned REG_CTRL  = 1;
    localparam int unsigned BIT_PUMP  = 0;
    localparam int unsigned BIT_VALVE = 1;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int unsigned DIV = 639
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        tick_o = (div_q == LAST);
        div_d  = tick_o ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    generate
        if (DIV > 1) begin : g_spacing
            p_tick_spacing_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/pwm_updown_core.sv
module pwm_updown_core
    import updown_pwm_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [CW-1:0] hold_i,
    output logic          pwm_o
);
    localparam logic [CW-1:0] TOP  = '1;
    localparam logic [CW-1:0] NEAR = TOP - 1'b1;
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        cnt_dir_e      dir;
        logic          pwm;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (st_q.dir == DIR_UP) begin
                if (st_q.cnt >= NEAR) begin
                    st_d.cnt = hold_i;
                    if (hold_i != '0) begin
                        st_d.pwm = ~st_q.pwm;
                        st_d.dir = DIR_DOWN;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt <= ONE) begin
                    st_d.cnt = hold_i;
                    if (hold_i != TOP) begin
                        st_d.pwm = ~st_q.pwm;
                        st_d.dir = DIR_UP;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: '0, dir: DIR_UP, pwm: 1'b0};
        else         st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;

    // R2: level and count move only on a tick
    p_toggle_on_tick_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pwm != $past(st_q.pwm)) |-> $past(tick_i));
    p_count_idle_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(st_q.cnt));
    // R6: a reload takes the holding value present on that tick
    p_reload_value_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && st_q.dir == DIR_UP && st_q.cnt >= NEAR) |=> (st_q.cnt == $past(hold_i)));
    // R4: zero holding value never leaves the low level
    p_zero_steady_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && hold_i == '0 && st_q.dir == DIR_UP) |=> $stable(st_q.pwm));
    // R5: full-scale holding value never leaves the high level
    p_full_steady_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && hold_i == TOP && st_q.dir == DIR_DOWN) |=> $stable(st_q.pwm));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import updown_pwm_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic [DW-1:0] hold_o,
    output logic          pump_en_o,
    output logic          valve_en_o
);
    localparam logic [AW-1:0] A_HOLD = AW'(REG_HOLD);
    localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);

    typedef struct packed {
        logic [DW-1:0] hold;
        logic [DW-1:0] ctrl;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en_i) begin
            if (wr_addr_i == A_HOLD) rg_d.hold = wr_data_i;
            if (wr_addr_i == A_CTRL) rg_d.ctrl = wr_data_i;
        end
        unique case (rd_addr_i)
            A_HOLD:  rd_data_o = rg_q.hold;
            A_CTRL:  rd_data_o = rg_q.ctrl;
            default: rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rg_q <= '0;
        else         rg_q <= rg_d;
    end

    assign hold_o     = rg_q.hold;
    assign pump_en_o  = rg_q.ctrl[BIT_PUMP];
    assign valve_en_o = rg_q.ctrl[BIT_VALVE];

    p_hold_write_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_HOLD) |=> (hold_o == $past(wr_data_i)));
    p_stray_write_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i != A_HOLD && wr_addr_i != A_CTRL) |=> ($stable(hold_o) && $stable(pump_en_o) && $stable(valve_en_o)));
endmodule

// File: rtl/updown_reload_pwm.sv
module updown_reload_pwm #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned TICK_DIV = 639
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              pump_pwm_o,
    output logic              valve_pwm_o
);
    logic              tick;
    logic              pwm;
    logic              pump_en;
    logic              valve_en;
    logic [DATA_W-1:0] hold;

    pwm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    pwm_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .hold_o     (hold),
        .pump_en_o  (pump_en),
        .valve_en_o (valve_en)
    );

    pwm_updown_core #(.CW(DATA_W)) u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .hold_i (hold),
        .pwm_o  (pwm)
    );

    always_comb begin
        pump_pwm_o  = pwm & pump_en  & ~valve_en;
        valve_pwm_o = pwm & valve_en & ~pump_en;
    end

    p_outputs_exclusive_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pump_pwm_o && valve_pwm_o));
    p_disabled_quiet_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwm |-> (!pump_pwm_o && !valve_pwm_o));
endmodule

// File: tb/updown_reload_pwm_tb.sv
`timescale 1ns/1ps
module updown_reload_pwm_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pump, valve;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    updown_reload_pwm #(.DATA_W(8), .ADDR_W(2), .TICK_DIV(DIV)) dut_i (
        .clk_i (clk), .rst_ni (rst_n),
        .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
        .rd_addr_i (rd_addr), .rd_data_o (rd_data),
        .pump_pwm_o (pump), .valve_pwm_o (valve)
    );

    localparam int NV = 4;
    localparam logic [7:0] H_TAB  [NV] = '{8'd1, 8'd37, 8'd128, 8'd254};
    localparam int         HI_TAB [NV] = '{4, 148, 512, 1016};
    localparam int         LO_TAB [NV] = '{1016, 872, 508, 4};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic meas(input logic lvl, output int n);
        n = 0;
        while (pump == lvl) begin n++; @(negedge clk); end
    endtask

    task automatic sync_rise();
        while (pump == 1'b1) @(negedge clk);
        while (pump == 1'b0) @(negedge clk);
    endtask

    task automatic count_high(input int len, output int n);
        n = 0;
        for (int k = 0; k < len; k++) begin n += int'(pump); @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, hi, lo, n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, v); chk("R1 hold readback", v, 0);
        rd(2'd1, v); chk("R1 ctrl readback", v, 0);
        chk("R1 pump low", int'(pump), 0);
        chk("R1 valve low", int'(valve), 0);

        // enable pump path; h = 0 from reset stays low (R4)
        wr(2'd1, 8'h01);
        count_high(1100, n); chk("R4 h=0 high clocks after reset", n, 0);

        // R3 / R2: table of holding values against expected high and low times
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, H_TAB[i]);
            sync_rise();
            meas(1'b1, hi);
            meas(1'b0, lo);
            chk("R3 R2 high clocks", hi, HI_TAB[i]);
            chk("R3 R2 low clocks", lo, LO_TAB[i]);
            chk("R3 period clocks", hi + lo, 255 * DIV);
        end

        // R6: write mid high phase; current phase keeps old length
        wr(2'd0, 8'd100);
        sync_rise();
        count_high(20, n);
        n += int'(pump);
        wr(2'd0, 8'd10);
        meas(1'b1, hi);
        chk("R6 high phase in progress", n + hi, 400);
        meas(1'b0, lo);
        chk("R6 low phase after reload", lo, 245 * DIV);
        meas(1'b1, hi);
        chk("R6 next high phase", hi, 10 * DIV);

        // R4: h = 0 steady low
        wr(2'd0, 8'd0);
        repeat (2200) @(negedge clk);
        count_high(1100, n); chk("R4 h=0 high clocks", n, 0);

        // R5: h = 255 steady high
        wr(2'd0, 8'd255);
        repeat (2200) @(negedge clk);
        count_high(1100, n); chk("R5 h=255 high clocks", n, 1100);

        // R7 / R8: enable gating with level held high
        wr(2'd1, 8'h01);
        chk("R7 pump shown", int'(pump), 1);
        chk("R7 valve hidden", int'(valve), 0);
        wr(2'd1, 8'h02);
        chk("R7 pump hidden", int'(pump), 0);
        chk("R7 valve shown", int'(valve), 1);
        wr(2'd1, 8'h03);
        chk("R8 pump forced low", int'(pump), 0);
        chk("R8 valve forced low", int'(valve), 0);
        repeat (300) @(negedge clk);
        chk("R8 valve still low", int'(valve), 0);
        wr(2'd1, 8'h00);
        chk("R7 both disabled pump", int'(pump), 0);
        chk("R7 both disabled valve", int'(valve), 0);

        // R9: readback and stray addresses
        wr(2'd1, 8'hA5);
        rd(2'd1, v); chk("R9 ctrl full readback", v, 8'hA5);
        wr(2'd2, 8'h5C);
        wr(2'd3, 8'h11);
        rd(2'd0, v); chk("R9 hold untouched by stray write", v, 255);
        rd(2'd1, v); chk("R9 ctrl untouched by stray write", v, 8'hA5);
        rd(2'd2, v); chk("R9 unmapped reads zero", v, 0);
        rd(2'd3, v); chk("R9 unmapped reads zero", v, 0);
        chk("R9 pump shows level after A5", int'(pump), 1);

        // R1: reset in mid run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, v); chk("R1 hold after second reset", v, 0);
        rd(2'd1, v); chk("R1 ctrl after second reset", v, 0);
        chk("R1 pump after second reset", int'(pump), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule